// File: doc/BRIEF.md
# Majority-Gate Two-Bit-Module Adder

This block adds two unsigned N-bit operands and returns an N-bit sum together with a carry-out. Every gate in its netlist is either a three-input majority function M(x,y,z) = xy + yz + xz or an inverter. AND and OR are majority gates with one input held at 0 or 1. The carry chain is a cascade of N/2 two-bit modules. Each module places exactly one majority level between its incoming carry and its outgoing carry, so the worst-case carry path grows by one level for every two bits. The carry into the adder is always zero. The lowest module therefore needs no carry input and no propagate term for bit 0.

An optional pipelined mode models the four-phase zone clocking used by such fabrics. The modules are split into groups of `GROUP_MODS` modules, and a register boundary sits between adjacent groups. Each boundary register holds the group carry, the operand bits that are still needed higher up, and the sum bits already formed below. The latency is therefore fixed at `ceil((N/2)/GROUP_MODS) - 1` cycles. With the defaults (N = 64, eight modules per group) there are four zones and a latency of 3 cycles. A valid flag travels with each operand pair. With `PIPELINED = 0` the block is purely combinational and the valid flag passes straight through.

Top module: `mg_adder`

## Requirements
- R1: `sum` equals (a + b) mod 2^N for the operand pair it belongs to.
- R2: `cout` equals bit N of the exact (N+1)-bit sum a + b, with the carry into the adder fixed at 0.
- R3: a = all ones and b = 1 ripples a carry from bit 0 through every position, giving `sum` = 0 and `cout` = 1.
- R4: When `PIPELINED` = 1, the result of a pair presented with `in_valid` = 1 appears on `sum` and `cout`, with `out_valid` = 1, exactly `ceil((N/2)/GROUP_MODS) - 1` rising edges later (3 with the defaults). `out_valid` repeats `in_valid` with the same delay.
- R5: When `PIPELINED` = 0, `out_valid` equals `in_valid`, and `sum` and `cout` reflect the current operands in the same cycle.
- R6: While `rst_n` is low, and in every output slot that belongs to an input cycle with `in_valid` = 0, `out_valid` is 0. This holds whatever the operand values are.
- R7: Pairs presented on back-to-back cycles produce independent results. A carry held in a zone register for one pair never changes the result of the pair before or after it.
- R8: Zero plus zero gives sum 0 and cout 0. Alternating patterns (0xAAAA...A + 0x5555...5, and 0xAAAA...A + 0xAAAA...A) give all ones with cout 0, and 0x5555...4 with cout 1, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the zone registers (unused when PIPELINED = 0) |
| rst_n | input | 1 | Asynchronous active-low reset of the zone registers |
| in_valid | input | 1 | Marks the current operand pair as meaningful |
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| out_valid | output | 1 | Marks `sum` and `cout` as the result of a valid pair |
| sum | output | N | Low N bits of a + b |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
In the pipelined build, a long carry can be crossing a zone register for one pair in the same cycle that the next pair enters the first zone and a third pair leaves the last. A bug there shows up as a carry leaking into a neighbour's result. The bench provokes this by issuing the full-ripple pair (all ones + 1) back to back with all-zero and alternating pairs, and by running random pairs on consecutive cycles with occasional empty slots. Each output slot is judged against the exact (N+1)-bit sum of the pair issued three cycles earlier, and against that pair's valid flag. The combinational build is run on the same stimulus and checked in the cycle the operands are applied.

// File: rtl/mg_adder_pkg.sv
package mg_adder_pkg;

    // Three-input majority: the only logic primitive besides the inverter.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

    // AND realised as a majority gate with one input held low.
    function automatic logic mg_and(input logic x, input logic y);
        return maj3(x, y, 1'b0);
    endfunction

    // OR realised as a majority gate with one input held high.
    function automatic logic mg_or(input logic x, input logic y);
        return maj3(x, y, 1'b1);
    endfunction

    // Sum bit from carry in, carry out and operands: M(~co, ci, M(x, y, ~ci)).
    function automatic logic mg_sum(input logic x, input logic y,
                                    input logic ci, input logic co);
        return maj3(~co, ci, maj3(x, y, ~ci));
    endfunction

endpackage

// File: rtl/mg_lsb_module.sv
// Least significant two-bit module: carry in is known to be zero, so bit 0
// needs neither a propagate term nor a carry majority.
module mg_lsb_module
    import mg_adder_pkg::*;
(
    input  logic [1:0] op_a,
    input  logic [1:0] op_b,
    output logic [1:0] part_sum,
    output logic       carry_out
);
    logic gen0;
    logic gen1;
    logic prop1;
    logic c1;

    always_comb begin
        gen0      = mg_and(op_a[0], op_b[0]);
        gen1      = mg_and(op_a[1], op_b[1]);
        prop1     = mg_or(op_a[1], op_b[1]);
        c1        = gen0;
        carry_out = maj3(prop1, gen1, c1);
        part_sum[0] = mg_sum(op_a[0], op_b[0], 1'b0, c1);
        part_sum[1] = mg_sum(op_a[1], op_b[1], c1, carry_out);
    end
endmodule

// File: rtl/mg_two_bit_module.sv
// General two-bit module. The group generate/propagate pair is formed from
// the operands alone, so one majority gate sits between carry_in and carry_out.
module mg_two_bit_module
    import mg_adder_pkg::*;
(
    input  logic [1:0] op_a,
    input  logic [1:0] op_b,
    input  logic       carry_in,
    output logic [1:0] part_sum,
    output logic       carry_out
);
    logic gen0, gen1, prop0, prop1;
    logic grp_gen, grp_prop, grp_kill_n;
    logic c_mid;

    always_comb begin
        gen0  = mg_and(op_a[0], op_b[0]);
        gen1  = mg_and(op_a[1], op_b[1]);
        prop0 = mg_or(op_a[0], op_b[0]);
        prop1 = mg_or(op_a[1], op_b[1]);
        // group terms: off the carry path
        grp_gen    = mg_or(gen1, mg_and(prop1, gen0));
        grp_prop   = mg_and(prop1, prop0);
        grp_kill_n = mg_or(grp_gen, grp_prop);
        // M(G, G|P, c) = G + P.c
        carry_out  = maj3(grp_gen, grp_kill_n, carry_in);
        c_mid      = maj3(prop0, gen0, carry_in);
        part_sum[0] = mg_sum(op_a[0], op_b[0], carry_in, c_mid);
        part_sum[1] = mg_sum(op_a[1], op_b[1], c_mid, carry_out);
    end
endmodule

// File: rtl/mg_adder.sv
module mg_adder #(
    parameter int N          = 64,
    parameter bit PIPELINED  = 1'b1,
    parameter int GROUP_MODS = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic         out_valid,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int NMOD  = N / 2;
    localparam int NG    = (NMOD + GROUP_MODS - 1) / GROUP_MODS;
    localparam int NREG  = (NG > 1) ? NG - 1 : 1;
    localparam int GBITS = 2 * GROUP_MODS;

    if ((N % 2) != 0 || N < 4) begin : g_bad_width
        $error("mg_adder: N must be even and at least 4");
    end
    if (GROUP_MODS < 1) begin : g_bad_group
        $error("mg_adder: GROUP_MODS must be at least 1");
    end

    typedef struct packed {
        logic         valid;
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] sum;
        logic         carry;
    } zone_t;

    // bits of the sum formed by zone g
    function automatic logic [N-1:0] zone_mask(input int g);
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) begin
            if (i >= g * GBITS && i < (g + 1) * GBITS) m[i] = 1'b1;
        end
        return m;
    endfunction

    zone_t        st_in  [NG];
    zone_t        zone_d [NREG];
    zone_t        zone_q [NREG];
    logic [N-1:0] mod_sum;
    logic [NMOD:1] mod_c;

    assign st_in[0] = '{valid: in_valid, a: a, b: b, sum: '0, carry: 1'b0};

    // ---------------- two-bit module cascade ----------------
    for (genvar m = 0; m < NMOD; m++) begin : g_mod
        localparam int G = m / GROUP_MODS;
        if (m == 0) begin : g_lsb
            mg_lsb_module u_lsb (
                .op_a      (st_in[G].a[1:0]),
                .op_b      (st_in[G].b[1:0]),
                .part_sum  (mod_sum[1:0]),
                .carry_out (mod_c[1])
            );
        end else begin : g_mid
            logic cin_w;
            if ((m % GROUP_MODS) == 0) begin : g_zone_entry
                assign cin_w = st_in[G].carry;
            end else begin : g_chain
                assign cin_w = mod_c[m];
            end
            mg_two_bit_module u_mod (
                .op_a      (st_in[G].a[2*m+1:2*m]),
                .op_b      (st_in[G].b[2*m+1:2*m]),
                .carry_in  (cin_w),
                .part_sum  (mod_sum[2*m+1:2*m]),
                .carry_out (mod_c[m+1])
            );
        end
    end

    // ---------------- next zone records ----------------
    always_comb begin
        for (int g = 0; g < NREG; g++) begin
            zone_d[g] = '0;
        end
        for (int g = 0; g < NG - 1; g++) begin
            zone_d[g]       = st_in[g];
            zone_d[g].sum   = (st_in[g].sum & ~zone_mask(g)) | (mod_sum & zone_mask(g));
            zone_d[g].carry = mod_c[(g + 1) * GROUP_MODS];
        end
    end

    // ---------------- zone boundaries ----------------
    if (PIPELINED && NG > 1) begin : g_zoned
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int g = 0; g < NREG; g++) zone_q[g] <= '0;
            end else begin
                for (int g = 0; g < NREG; g++) zone_q[g] <= zone_d[g];
            end
        end
        for (genvar g = 1; g < NG; g++) begin : g_link
            assign st_in[g] = zone_q[g-1];
        end
    end else begin : g_flat
        always_comb begin
            for (int g = 0; g < NREG; g++) zone_q[g] = zone_d[g];
        end
        for (genvar g = 1; g < NG; g++) begin : g_link
            assign st_in[g] = zone_d[g-1];
        end
    end

    // ---------------- final zone drives the outputs ----------------
    assign out_valid = st_in[NG-1].valid;
    assign sum       = (st_in[NG-1].sum & ~zone_mask(NG - 1)) | (mod_sum & zone_mask(NG - 1));
    assign cout      = mod_c[NMOD];

endmodule

// File: rtl/mg_adder_chk.sv
module mg_adder_chk #(
    parameter int N          = 64,
    parameter bit PIPELINED  = 1'b1,
    parameter int GROUP_MODS = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         out_valid,
    input logic [N-1:0] sum,
    input logic         cout
);
    localparam int NG    = (N / 2 + GROUP_MODS - 1) / GROUP_MODS;
    localparam int LAT   = PIPELINED ? NG - 1 : 0;
    localparam int DEPTH = (LAT > 0) ? LAT : 1;

    logic [N:0] ref_q [DEPTH];
    logic       vld_q [DEPTH];
    int         since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ref_q[i] <= '0;
                vld_q[i] <= 1'b0;
            end
            since_rst <= 0;
        end else begin
            ref_q[0] <= {1'b0, a} + {1'b0, b};
            vld_q[0] <= in_valid;
            for (int i = 1; i < DEPTH; i++) begin
                ref_q[i] <= ref_q[i-1];
                vld_q[i] <= vld_q[i-1];
            end
            if (since_rst < DEPTH + 1) since_rst <= since_rst + 1;
        end
    end

    if (LAT > 0) begin : g_zoned
        AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (sum == ref_q[LAT-1][N-1:0])); // R1
        AST_COUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (cout == ref_q[LAT-1][N])); // R2
        AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == vld_q[LAT-1]); // R4
        AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst < LAT) |-> !out_valid); // R6
    end else begin : g_flat
        AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (sum == a + b)); // R1
        AST_COUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ({cout, sum} == {1'b0, a} + {1'b0, b})); // R2
        AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid); // R5
        AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |-> !out_valid); // R6
    end
endmodule

bind mg_adder mg_adder_chk #(
    .N(N), .PIPELINED(PIPELINED), .GROUP_MODS(GROUP_MODS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .sum(sum), .cout(cout)
);

// File: tb/mg_adder_bench.sv
`timescale 1ns/1ps
module mg_adder_bench;
    localparam int N   = 64;
    localparam int LAT = 3;
    localparam real HALF = 2.5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic         out_valid, out_valid_f;
    logic [N-1:0] sum, sum_f;
    logic         cout, cout_f;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [N:0] exp_h [4];
    logic       vld_h [4];
    string      tag_h [4];

    always #(HALF) clk = ~clk;

    mg_adder #(.N(N), .PIPELINED(1'b1), .GROUP_MODS(8)) u_mg_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(out_valid), .sum(sum), .cout(cout));

    mg_adder #(.N(N), .PIPELINED(1'b0), .GROUP_MODS(8)) u_mg_adder_flat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(out_valid_f), .sum(sum_f), .cout(cout_f));

    function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic check_vec(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One cycle: judge the zoned output slot, drive a new pair, judge the flat copy.
    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic v, input string tag);
        int idx;
        logic [N:0] e;
        @(negedge clk);
        idx = (cyc + 1) % 4;   // pair issued LAT = 3 cycles ago
        check_bit({"R4 R6 ", tag_h[idx]}, "zoned out_valid", out_valid, vld_h[idx]);
        if (vld_h[idx]) begin
            check_vec({"R1 R7 ", tag_h[idx]}, "zoned sum", sum, exp_h[idx][N-1:0]);
            check_bit({"R2 R7 ", tag_h[idx]}, "zoned cout", cout, exp_h[idx][N]);
        end
        a = x; b = y; in_valid = v;
        #1;
        e = ref_add(x, y);
        check_bit({"R5 R6 ", tag}, "flat out_valid", out_valid_f, v);
        if (v) begin
            check_vec({"R1 ", tag}, "flat sum", sum_f, e[N-1:0]);
            check_bit({"R2 ", tag}, "flat cout", cout_f, e[N]);
        end
        exp_h[cyc % 4] = e;
        vld_h[cyc % 4] = v;
        tag_h[cyc % 4] = tag;
        cyc++;
    endtask

    initial begin
        #(2.0 * HALF * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] ra, rb;
        logic rv;
        for (int i = 0; i < 4; i++) begin
            exp_h[i] = '0; vld_h[i] = 1'b0; tag_h[i] = "reset";
        end
        void'($urandom(32'h5EED_0A11));
        // R6: reset state with valid asserted at the inputs
        in_valid = 1'b1; a = '1; b = '1;
        repeat (3) @(negedge clk);
        check_bit("R6", "zoned out_valid in reset", out_valid, 1'b0);
        in_valid = 1'b0; a = '0; b = '0;
        @(negedge clk);
        rst_n = 1'b1;

        apply('0, '0, 1'b1, "R8 zero");
        apply('1, 64'd1, 1'b1, "R3 ripple");
        apply('0, '0, 1'b1, "R7 after ripple");
        apply('1, 64'd1, 1'b1, "R3 ripple again");
        apply({32{2'b10}}, {32{2'b01}}, 1'b1, "R8 alt mixed");
        apply('1, '1, 1'b1, "R2 ones");
        apply({32{2'b10}}, {32{2'b10}}, 1'b1, "R8 alt same");
        apply('1, 64'd1, 1'b0, "R6 bubble ripple");
        apply({1'b1, 63'd0}, {1'b1, 63'd0}, 1'b1, "R2 top carry");
        apply('1, 64'd1, 1'b1, "R7 ripple then empty");
        apply('1, '1, 1'b0, "R6 bubble ones");
        apply(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b1, "R7 zone carry");

        for (int k = 0; k < 10000; k++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rv = ($urandom % 8) != 0;
            if (k % 97 == 0) rb = ~ra + 64'd1;   // exact wrap to zero
            apply(ra, rb, rv, "R1 random");
        end
        for (int k = 0; k < LAT + 1; k++) apply('0, '0, 1'b0, "R6 flush");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule